// File: doc/BRIEF.md
# General-Purpose I/O Port

This block is an eight-pin digital I/O port that sits on a small register bus inside a microcontroller. Software reaches it through three byte-wide registers: one holds the driven levels, one chooses output or input for each pin, and one reports the sampled pad levels. Every write carries a per-bit mask, so one pin can be set or cleared without a read-modify-write sequence that could disturb its neighbours.

The port drives an output enable, an output level and a pull-up enable for each pad, and it samples the pad inputs through a two-stage synchronizer. Writing ones to the input-level register does not store anything there. Instead, it inverts the matching bits of the output data register. A single pull-up kill input, driven from a system control register, turns off every pull-up at once.

Top module: `gpio_port`

## Requirements
- R1: After reset, the direction and output data registers are zero. Every pin is an input, pad_oe, pad_out and pad_pu are all zero, and the input-level register reads zero.
- R2: A write with wr_en high to address 1 (direction) or address 2 (output data) updates only the bits whose wr_mask bit is 1, taking their values from wr_data. Bits with mask 0 keep their value. Both registers read back their contents at their addresses.
- R3: A write to address 0 (input levels) inverts each output data bit where both wr_data and wr_mask are 1. All other data bits are unchanged.
- R4: pad_oe equals the direction register bit for bit, and pad_out equals the output data register bit for bit.
- R5: With pu_kill low, pad_pu of a pin is 1 exactly when its direction bit is 0 and its data bit is 1.
- R6: With pu_kill high, pad_pu is all zero whatever the register contents are.
- R7: pad_in reaches the address 0 read value after exactly two rising clock edges. Writes to address 0 never alter that read value.
- R8: A read of address 3 returns zero, and a write to address 3 changes no register.
- R9: rd_data is zero while rd_en is low, and shows the addressed register while rd_en is high. A read has no side effects.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 2 | Register select: 0 input levels, 1 direction, 2 output data, 3 unused |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 8 | Write data |
| wr_mask | input | 8 | Per-bit write mask, 1 = affected |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 8 | Read data, zero when not reading |
| pu_kill | input | 1 | Global pull-up disable |
| pad_in | input | 8 | Raw pad input levels |
| pad_oe | output | 8 | Per-pin output enable |
| pad_out | output | 8 | Per-pin driven level |
| pad_pu | output | 8 | Per-pin pull-up enable |

## Verification
The write path is exercised with a full-mask byte write, a single-bit set, a single-bit clear, a nibble-masked write, toggles with full and partial masks, an all-zero toggle and a write to the unused address. Together these patterns separate a mask that is ignored from one that is inverted, a toggle that stores its data from one that inverts, and a decoder that leaks writes into the wrong register. The pull-up output is checked against a mix of inputs and outputs, with the kill input both low and high. A pad level change is read back one edge and two edges later, which pins the synchronizer depth to exactly two stages.

// File: rtl/gpio_port.sv
module gpio_port #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       addr,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] wr_data,
  input  logic [WIDTH-1:0] wr_mask,
  input  logic             rd_en,
  output logic [WIDTH-1:0] rd_data,
  input  logic             pu_kill,
  input  logic [WIDTH-1:0] pad_in,
  output logic [WIDTH-1:0] pad_oe,
  output logic [WIDTH-1:0] pad_out,
  output logic [WIDTH-1:0] pad_pu
);
  localparam logic [1:0] A_PIN = 2'd0;
  localparam logic [1:0] A_DIR = 2'd1;
  localparam logic [1:0] A_DAT = 2'd2;

  logic [WIDTH-1:0] dir_q, dat_q, meta_q, pin_q;
  logic [WIDTH-1:0] sel_bits;

  assign sel_bits = wr_data & wr_mask;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dir_q <= '0;
      dat_q <= '0;
    end else if (wr_en) begin
      case (addr)
        A_DIR:   dir_q <= (dir_q & ~wr_mask) | sel_bits;
        A_DAT:   dat_q <= (dat_q & ~wr_mask) | sel_bits;
        A_PIN:   dat_q <= dat_q ^ sel_bits;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      meta_q <= '0;
      pin_q  <= '0;
    end else begin
      meta_q <= pad_in;
      pin_q  <= meta_q;
    end
  end

  always_comb begin
    rd_data = '0;
    if (rd_en) begin
      case (addr)
        A_PIN:   rd_data = pin_q;
        A_DIR:   rd_data = dir_q;
        A_DAT:   rd_data = dat_q;
        default: rd_data = '0;
      endcase
    end
  end

  assign pad_oe  = dir_q;
  assign pad_out = dat_q;
  assign pad_pu  = ~dir_q & dat_q & {WIDTH{~pu_kill}};

  // cycles since reset, saturating, for the latency check
  logic [1:0] age_q;
  always_ff @(posedge clk) begin
    if (!rst_n)             age_q <= '0;
    else if (age_q != 2'd2) age_q <= age_q + 2'd1;
  end

  assert_dir_mask_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_DIR) |=> (((dir_q ^ $past(dir_q)) & ~$past(wr_mask)) == '0));

  assert_dat_mask_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_DAT) |=> (((dat_q ^ $past(dat_q)) & ~$past(wr_mask)) == '0));

  assert_toggle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_PIN) |=> (pad_out == ($past(pad_out) ^ ($past(wr_data) & $past(wr_mask)))));

  assert_pu_input_only_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_pu & pad_oe) == '0);

  assert_pu_kill_R6: assert property (@(posedge clk) disable iff (!rst_n)
    pu_kill |-> (pad_pu == '0));

  assert_sync_latency_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == A_PIN && age_q == 2'd2) |-> (rd_data == $past(pad_in, 2)));

  assert_unused_addr_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 2'd3) |=> ($stable(pad_oe) && $stable(pad_out)));
endmodule

// File: tb/gpio_port_tb.sv
`timescale 1ns/1ps
module gpio_port_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] addr = '0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic [7:0] wr_mask = '0;
  logic       rd_en = 1'b0;
  logic [7:0] rd_data;
  logic       pu_kill = 1'b0;
  logic [7:0] pad_in = '0;
  logic [7:0] pad_oe, pad_out, pad_pu;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  gpio_port #(.WIDTH(8)) dut_i (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
    .wr_mask(wr_mask), .rd_en(rd_en), .rd_data(rd_data), .pu_kill(pu_kill),
    .pad_in(pad_in), .pad_oe(pad_oe), .pad_out(pad_out), .pad_pu(pad_pu)
  );

  // {addr, mask, data, expected direction, expected output data}
  localparam logic [33:0] VEC [0:9] = '{
    {2'd1, 8'hFF, 8'h0F, 8'h0F, 8'h00},
    {2'd2, 8'hFF, 8'h3C, 8'h0F, 8'h3C},
    {2'd1, 8'h80, 8'hFF, 8'h8F, 8'h3C},
    {2'd2, 8'h04, 8'h00, 8'h8F, 8'h38},
    {2'd0, 8'hFF, 8'h81, 8'h8F, 8'hB9},
    {2'd0, 8'h0F, 8'hFF, 8'h8F, 8'hB6},
    {2'd0, 8'hFF, 8'h00, 8'h8F, 8'hB6},
    {2'd3, 8'hFF, 8'hFF, 8'h8F, 8'hB6},
    {2'd1, 8'h01, 8'h00, 8'h8E, 8'hB6},
    {2'd2, 8'hF0, 8'h5A, 8'h8E, 8'h56}
  };

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic do_write(input logic [1:0] a, input logic [7:0] m, input logic [7:0] d);
    @(negedge clk);
    addr = a; wr_mask = m; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; wr_mask = '0; wr_data = '0;
  endtask

  task automatic do_read(input logic [1:0] a, output logic [7:0] v);
    addr = a; rd_en = 1'b1;
    #0.5;
    v = rd_data;
    rd_en = 1'b0;
    #0.1;
  endtask

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 oe", pad_oe, 8'h00);
    chk("R1 out", pad_out, 8'h00);
    chk("R1 pu", pad_pu, 8'h00);
    do_read(2'd0, v); chk("R1 pin read", v, 8'h00);
    do_read(2'd1, v); chk("R1 dir read", v, 8'h00);
    do_read(2'd2, v); chk("R1 dat read", v, 8'h00);

    for (int i = 0; i < 10; i++) begin
      logic [7:0] ed, eo;
      ed = VEC[i][15:8];
      eo = VEC[i][7:0];
      do_write(VEC[i][33:32], VEC[i][31:24], VEC[i][23:16]);
      chk("R4 oe (R2/R3/R8 write)", pad_oe, ed);
      chk("R4 out (R2/R3/R8 write)", pad_out, eo);
      chk("R5 pu", pad_pu, ~ed & eo);
      do_read(2'd1, v); chk("R2 dir readback", v, ed);
      do_read(2'd2, v); chk("R2 dat readback", v, eo);
    end

    // dir 8E, data 56
    chk("R5 pu mix", pad_pu, 8'h50);
    pu_kill = 1'b1; #0.5;
    chk("R6 pu killed", pad_pu, 8'h00);
    pu_kill = 1'b0; #0.5;
    chk("R6 pu restored", pad_pu, 8'h50);

    do_read(2'd3, v); chk("R8 unused read", v, 8'h00);
    addr = 2'd2; rd_en = 1'b0; #0.5;
    chk("R9 idle rd_data", rd_data, 8'h00);

    @(negedge clk);
    pad_in = 8'hA5;
    do_read(2'd0, v); chk("R7 latency 0", v, 8'h00);
    @(negedge clk);
    do_read(2'd0, v); chk("R7 latency 1", v, 8'h00);
    @(negedge clk);
    do_read(2'd0, v); chk("R7 latency 2", v, 8'hA5);
    do_write(2'd0, 8'hFF, 8'hFF);
    do_read(2'd0, v); chk("R7 pin read-only", v, 8'hA5);
    chk("R3 full toggle", pad_out, 8'hA9);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule